// File: doc/BRIEF.md
# Saturating Bidirectional Arithmetic Shifter

This block shifts a signed 32-bit operand by a signed 6-bit count. A count of zero or more shifts left, filling the low bits with zeros. If significant bits would be lost, the result clamps to the largest or smallest signed 32-bit value. A negative count shifts right arithmetically by its magnitude, from 1 to 32 places. The datapath is combinational: the result and the decode verdict follow the inputs in the same cycle.

The count comes from one of two sources, chosen by an instruction-format input. One source is a 9-bit immediate carried inside the raw instruction word. The other is a register value supplied on its own port. The instruction word is also decoded to confirm that it encodes this shift in the chosen format.

Two status flags are registered. They change only on a clock edge where the strobe is high and the decode matches. The plain overflow flag records whether the last accepted left shift lost significant bits. The sticky overflow flag remembers any overflow until reset, and is built as a two-state machine:

- States: `STK_CLEAR` and `STK_SET`.
- `T_ARM` goes from `STK_CLEAR` to `STK_SET` on an accepted overflowing shift.
- `T_HOLD_CLEAR` keeps `STK_CLEAR` in every other cycle.
- `T_HOLD_SET` keeps `STK_SET` in every cycle that is not a reset.
- `T_RESET` returns either state to `STK_CLEAR` on a synchronous reset.

A carry flag passes through the block untouched.

Top module: `sat_shift_unit`

## Requirements
- R1: The count is the low 6 bits of the selected source, read as two's complement (-32 to +31). With `fmt_imm`=1 the source is the immediate in `insn[20:12]`, so only `insn[17:12]` matter. With `fmt_imm`=0 the source is `count_reg`, and only `count_reg[5:0]` matter.
- R2: A count n >= 0 that loses no significant bits gives `result` = `opnd_a` shifted left by n, with zero fill.
- R3: A negative count shifts `opnd_a` right by its magnitude, filling with copies of bit 31. A count of -32 gives all zeros for a non-negative operand and all ones for a negative operand.
- R4: A left shift whose exact result lies outside the signed 32-bit range gives 0x7FFFFFFF for a non-negative operand and 0x80000000 for a negative operand.
- R5: On an accepted cycle, `ovf` is loaded one edge later: 1 if the exact left-shift result was out of range, otherwise 0. A right shift always loads 0.
- R6: `sticky_ovf` becomes 1 at the edge of an accepted overflowing shift. It then stays 1 until reset.
- R7: `op_ok` is 1 in two cases. With `fmt_imm`=1: `insn[7:0]`=0x8F and `insn[27:21]`=0x02. With `fmt_imm`=0: `insn[7:0]`=0x0F and `insn[27:20]`=0x02. A cycle is accepted only when `valid` and `op_ok` are both 1. In any other cycle both flags keep their values.
- R8: `carry_out` always equals `carry_in`.
- R9: When `rst` is 1 at a clock edge, both `ovf` and `sticky_ovf` read 0 after that edge.
- R10: `result[31]` always equals `opnd_a[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears both flags |
| valid | input | 1 | Strobe that lets a matching operation update the flags |
| fmt_imm | input | 1 | 1: count from the immediate field; 0: count from `count_reg` |
| insn | input | 32 | Raw instruction word, used for decode and the immediate |
| count_reg | input | 32 | Register value used as the count source |
| opnd_a | input | 32 | Signed operand to be shifted |
| carry_in | input | 1 | Incoming carry flag |
| result | output | 32 | Shifted and saturated result |
| op_ok | output | 1 | Instruction word matches the selected format |
| ovf | output | 1 | Registered overflow flag |
| sticky_ovf | output | 1 | Registered sticky overflow flag |
| carry_out | output | 1 | Carry flag, equal to `carry_in` |

## Verification
The shifter is driven with both count sources and several operand patterns.
- Directed patterns cover small left shifts, the zero count, right shifts of 1, 3 and 32 on positive and negative operands, and left shifts that land exactly on the range edge, such as 0x40000000 by 1 and -1 by 31. These separate a correct overflow test from one that checks only the discarded bits or only the sign.
- Junk in the unused high bits of both count sources shows whether the 6-bit count is taken from the right bits.
- Mismatching opcodes and a low strobe, each combined with an overflowing operand, show whether flag updates are properly gated.
- A long pseudo-random run then compares the result and both flags with a behavioural model on every clock.

// File: rtl/sat_shift_pkg.sv
`timescale 1ns/1ps
package sat_shift_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 6;
    localparam int IMM_W    = 9;
    localparam int OPC_W    = 8;
    localparam int IMM_LSB  = 12;
    localparam int IMM_SUB_LSB = 21;
    localparam int REG_SUB_LSB = 20;
    localparam logic [OPC_W-1:0] OPC_IMM = 8'h8F;
    localparam logic [OPC_W-1:0] OPC_REG = 8'h0F;
    localparam logic [7:0]       SUB_OP  = 8'h02;

    typedef enum logic {
        STK_CLEAR = 1'b0,
        STK_SET   = 1'b1
    } stk_state_e;
endpackage

// File: rtl/shas_decode.sv
`timescale 1ns/1ps
module shas_decode
    import sat_shift_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          fmt_imm,
    input  logic [DW-1:0] insn,
    input  logic [DW-1:0] count_reg,
    output logic [CW-1:0] cnt,
    output logic          op_ok
);
    localparam int IMM_MSB     = IMM_LSB + IMM_W - 1;
    localparam int IMM_SUB_W   = DW - 4 - IMM_SUB_LSB;
    localparam int REG_SUB_W   = DW - 4 - REG_SUB_LSB;

    logic [IMM_W-1:0]     imm_field;
    logic [IMM_SUB_W-1:0] imm_sub;
    logic [REG_SUB_W-1:0] reg_sub;
    logic                 imm_hit;
    logic                 reg_hit;
    logic                 unused_bits;

    always_comb begin
        imm_field = insn[IMM_MSB:IMM_LSB];
        imm_sub   = insn[DW-5:IMM_SUB_LSB];
        reg_sub   = insn[DW-5:REG_SUB_LSB];
        imm_hit   = (insn[OPC_W-1:0] == OPC_IMM) &&
                    (imm_sub == SUB_OP[IMM_SUB_W-1:0]);
        reg_hit   = (insn[OPC_W-1:0] == OPC_REG) &&
                    (reg_sub == SUB_OP[REG_SUB_W-1:0]);
        op_ok     = fmt_imm ? imm_hit : reg_hit;
        cnt       = fmt_imm ? imm_field[CW-1:0] : count_reg[CW-1:0];
    end

    assign unused_bits = ^{imm_field[IMM_W-1:CW], count_reg[DW-1:CW],
                           insn[DW-1:DW-4], insn[11:8]};
endmodule

// File: rtl/shas_core.sv
`timescale 1ns/1ps
module shas_core
    import sat_shift_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic [DW-1:0] opnd,
    input  logic [CW-1:0] cnt,
    output logic [DW-1:0] res,
    output logic          ovf_raw
);
    localparam int WW = 2 * DW;
    localparam logic [DW-1:0] SAT_POS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SAT_NEG = {1'b1, {(DW-1){1'b0}}};

    logic                 go_right;
    logic [CW-1:0]        mag;
    logic [WW-1:0]        wide;
    logic [DW:0]          top_bits;
    logic signed [DW-1:0] rsh;

    always_comb begin
        go_right = cnt[CW-1];
        mag      = go_right ? (~cnt + 1'b1) : cnt;
        wide     = {{DW{opnd[DW-1]}}, opnd} << mag;
        top_bits = wide[WW-1:DW-1];
        rsh      = $signed(opnd) >>> mag;
        ovf_raw  = !go_right && !((top_bits == '0) || (top_bits == '1));
        if (go_right) begin
            res = rsh;
        end else if (ovf_raw) begin
            res = opnd[DW-1] ? SAT_NEG : SAT_POS;
        end else begin
            res = wide[DW-1:0];
        end
    end
endmodule

// File: rtl/shas_flags.sv
`timescale 1ns/1ps
module shas_flags
    import sat_shift_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic accept,
    input  logic ovf_raw,
    output logic ovf,
    output logic sticky_ovf
);
    stk_state_e state_q;
    stk_state_e state_d;
    logic       ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STK_CLEAR;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                ovf_q <= ovf_raw;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            STK_CLEAR: if (accept && ovf_raw) state_d = STK_SET;
            STK_SET:   state_d = STK_SET;
            default:   state_d = STK_CLEAR;
        endcase
    end

    always_comb begin
        sticky_ovf = (state_q == STK_SET);
        ovf        = ovf_q;
    end
endmodule

// File: rtl/sat_shift_unit.sv
`timescale 1ns/1ps
module sat_shift_unit
    import sat_shift_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid,
    input  logic              fmt_imm,
    input  logic [DATA_W-1:0] insn,
    input  logic [DATA_W-1:0] count_reg,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              op_ok,
    output logic              ovf,
    output logic              sticky_ovf,
    output logic              carry_out
);
    logic [CNT_W-1:0] cnt;
    logic             ovf_raw;
    logic             accept;

    shas_decode #(.DW(DATA_W), .CW(CNT_W)) i_decode (
        .fmt_imm   (fmt_imm),
        .insn      (insn),
        .count_reg (count_reg),
        .cnt       (cnt),
        .op_ok     (op_ok)
    );

    shas_core #(.DW(DATA_W), .CW(CNT_W)) i_core (
        .opnd    (opnd_a),
        .cnt     (cnt),
        .res     (result),
        .ovf_raw (ovf_raw)
    );

    assign accept    = valid && op_ok;
    assign carry_out = carry_in;

    shas_flags i_flags (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .ovf_raw    (ovf_raw),
        .ovf        (ovf),
        .sticky_ovf (sticky_ovf)
    );
endmodule

// File: rtl/shas_checker.sv
`timescale 1ns/1ps
module shas_checker (
    input logic        clk,
    input logic        rst,
    input logic        valid,
    input logic        fmt_imm,
    input logic [31:0] insn,
    input logic [31:0] count_reg,
    input logic [31:0] opnd_a,
    input logic        carry_in,
    input logic [31:0] result,
    input logic        op_ok,
    input logic        ovf,
    input logic        sticky_ovf,
    input logic        carry_out
);
    logic cnt_neg;
    assign cnt_neg = fmt_imm ? insn[17] : count_reg[5];

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!ovf && !sticky_ovf)); // R9

    AST_STICKY_KEEPS: assert property (@(posedge clk) disable iff (rst)
        sticky_ovf |=> sticky_ovf); // R6

    AST_OVF_ARMS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (valid && op_ok && ovf && !$stable(ovf)) |-> sticky_ovf); // R6

    AST_RIGHT_CLEARS_OVF: assert property (@(posedge clk) disable iff (rst)
        (valid && op_ok && cnt_neg) |=> !ovf); // R5

    AST_IDLE_FLAGS_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(valid && op_ok) |=> ($stable(ovf) && $stable(sticky_ovf))); // R7

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        result[31] == opnd_a[31]); // R10

    AST_CARRY_PASS: assert property (@(posedge clk) disable iff (rst)
        carry_out == carry_in); // R8
endmodule

bind sat_shift_unit shas_checker i_shas_checker (.*);

// File: tb/test_sat_shift_unit.sv
`timescale 1ns/1ps
module test_sat_shift_unit;
    logic        clk = 1'b0;
    logic        rst, valid, fmt_imm, carry_in;
    logic [31:0] insn, count_reg, opnd_a;
    logic [31:0] result;
    logic        op_ok, ovf, sticky_ovf, carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit m_ovf    = 1'b0;
    bit m_stk    = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #10 clk = ~clk;

    sat_shift_unit i_sat_shift_unit (
        .clk(clk), .rst(rst), .valid(valid), .fmt_imm(fmt_imm), .insn(insn),
        .count_reg(count_reg), .opnd_a(opnd_a), .carry_in(carry_in),
        .result(result), .op_ok(op_ok), .ovf(ovf), .sticky_ovf(sticky_ovf),
        .carry_out(carry_out)
    );

    function automatic logic [31:0] mk_imm(input logic [8:0] c9);
        return {4'd2, 7'h02, c9, 4'd1, 8'h8F};
    endfunction

    function automatic logic [31:0] mk_reg();
        return {4'd3, 8'h02, 4'hA, 4'd5, 4'd4, 8'h0F};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input bit r, input bit v, input bit f, input logic [31:0] iw,
                        input logic [31:0] cr, input logic [31:0] a, input bit cy);
        int          n;
        logic [5:0]  c6;
        longint      wide;
        logic [31:0] e_res;
        bit          e_ovf, e_ok, acc;
        string       rq;
        rst = r; valid = v; fmt_imm = f; insn = iw; count_reg = cr;
        opnd_a = a; carry_in = cy;
        #4;
        c6 = f ? iw[17:12] : cr[5:0];
        n  = c6[5] ? int'(c6) - 64 : int'(c6);
        e_ovf = 1'b0;
        if (n >= 0) begin
            wide = longint'($signed(a)) * (longint'(1) << n);
            if (wide > 64'sd2147483647 || wide < -64'sd2147483648) begin
                e_ovf = 1'b1;
                e_res = a[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
                rq = "R4";
            end else begin
                e_res = wide[31:0];
                rq = "R2";
            end
        end else begin
            wide  = longint'($signed(a)) >>> (-n);
            e_res = wide[31:0];
            rq = "R3";
        end
        e_ok = f ? (iw[7:0] == 8'h8F && iw[27:21] == 7'h02)
                 : (iw[7:0] == 8'h0F && iw[27:20] == 8'h02);
        chk(result === e_res, rq, "result (count via R1)", result, e_res);
        chk(op_ok === e_ok, "R7", "op_ok", {31'd0, op_ok}, {31'd0, e_ok});
        chk(carry_out === cy, "R8", "carry_out", {31'd0, carry_out}, {31'd0, cy});
        chk(result[31] === a[31], "R10", "sign", result, a);
        @(posedge clk);
        acc = v && e_ok;
        if (r) begin
            m_ovf = 1'b0; m_stk = 1'b0;
        end else if (acc) begin
            m_ovf = e_ovf;
            if (e_ovf) m_stk = 1'b1;
        end
        #2;
        chk(ovf === m_ovf, r ? "R9" : (acc ? "R5" : "R7"), "ovf",
            {31'd0, ovf}, {31'd0, m_ovf});
        chk(sticky_ovf === m_stk, r ? "R9" : "R6", "sticky_ovf",
            {31'd0, sticky_ovf}, {31'd0, m_stk});
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R9: reset state
        step(1, 0, 1, mk_imm(9'd0), 0, 32'h0, 0);
        step(1, 1, 1, mk_imm(9'd0), 0, 32'h0, 1);
        // R2: plain left shifts, both count sources (R1)
        step(0, 1, 1, mk_imm(9'd4), 0, 32'h0000_0123, 0);
        step(0, 1, 0, mk_reg(), 32'd8, 32'hFFFF_FF00, 1);
        step(0, 1, 0, mk_reg(), 32'd0, 32'h8765_4321, 0);
        // R1: junk in unused high bits of both sources
        step(0, 1, 1, mk_imm(9'h1C3), 0, 32'h0000_0005, 0);
        step(0, 1, 0, mk_reg(), 32'hFFFF_FF02, 32'h0000_0005, 0);
        // R3: right shifts, including -32
        step(0, 1, 1, mk_imm(9'h03D), 0, 32'h8000_0010, 0);
        step(0, 1, 1, mk_imm(9'h020), 0, 32'h7FFF_FFFF, 0);
        step(0, 1, 0, mk_reg(), 32'h20, 32'h8000_0000, 1);
        step(0, 1, 0, mk_reg(), 32'h3F, 32'h0000_0003, 0);
        // R2 range edges: no overflow
        step(0, 1, 1, mk_imm(9'd31), 0, 32'hFFFF_FFFF, 0);
        step(0, 1, 1, mk_imm(9'd31), 0, 32'h0000_0000, 0);
        step(0, 1, 1, mk_imm(9'd1), 0, 32'hC000_0000, 0);
        // R7: overflow pattern but not accepted
        step(0, 0, 1, mk_imm(9'd31), 0, 32'h0000_0001, 0);
        step(0, 1, 1, mk_reg(), 0, 32'h0000_0001, 0);
        step(0, 1, 0, mk_imm(9'd31), 32'd31, 32'h0000_0001, 0);
        step(0, 1, 1, mk_imm(9'd31) ^ 32'h0020_0000, 0, 32'h0000_0001, 0);
        // R4/R5/R6: overflow both signs, then sticky holds
        step(0, 1, 1, mk_imm(9'd1), 0, 32'h4000_0000, 0);
        step(0, 1, 0, mk_reg(), 32'd2, 32'hA000_0000, 1);
        step(0, 1, 1, mk_imm(9'd1), 0, 32'h0000_0001, 0);
        step(0, 1, 1, mk_imm(9'h03F), 0, 32'h0000_0100, 0);
        step(0, 0, 1, mk_imm(9'd0), 0, 32'h0, 0);
        // R9: reset mid-run clears both flags
        step(1, 1, 1, mk_imm(9'd20), 0, 32'h0001_0000, 0);
        step(0, 1, 1, mk_imm(9'd2), 0, 32'h0000_0001, 0);
        // mixed pseudo-random run
        for (int i = 0; i < 400; i++) begin
            logic [31:0] s1, s2, s3;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            s1 = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            s2 = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            s3 = seed;
            step(s3[7:0] == 8'h00, s3[8] | s3[9], s3[10],
                 s3[11] ? mk_imm(s3[20:12]) : (s3[12] ? mk_reg() : s1),
                 s2, s3[13] ? (s1 >> s3[18:14]) : s1, s3[21]);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule